// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block sits between a host read port and a 16-bit word array and turns host requests into array addresses. After reset it works in asynchronous mode. Each clock edge with the chip select high passes the host address straight to the array, so every read is a random single-word read. In this mode the ready output shows whether a program or erase job elsewhere on the die is still busy.

When the configuration register selects synchronous mode, an address-valid strobe captures a start address. The block then waits a programmable number of clocks and produces one data beat per clock after that. Ready is high on every beat. The address runs linearly but wraps inside an aligned window of 8, 16 or 32 words, and it keeps wrapping until the chip select drops or a new strobe starts another burst.

The array is modelled as a synchronous RAM with a registered read port and a write port for loading contents.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is high, and at the first edge after it, the block is in asynchronous mode, and `rdy_o` and `data_oe_o` are low. At reset `arr_addr_o` is zero.
- R2: In asynchronous mode, each edge with `cs_i` high loads `addr_i` into `arr_addr_o`. After the same edge, `rdata_o` holds the array word at that address.
- R3: In asynchronous mode, `rdy_o` after an edge equals the inverse of `busy_i` sampled at that edge.
- R4: A write of `cfg_i` (with `cs_i` and `cfg_we_i` high) takes effect at the next edge. The fields are: bit 0 = 1 selects synchronous mode; bits 2:1 give the burst length (0 = 8, 1 = 16, 2 and 3 = 32 words); bits 6:3 give the latency L in clocks.
- R5: In synchronous mode, an edge with `cs_i` and `avalid_i` high captures `addr_i` as start address S. `rdy_o` is low after that edge and after the next L edges.
- R6: Beat k (k = 0, 1, ...) is visible after the (L+1+k)-th edge following the start edge. On that beat `rdy_o` is high and `rdata_o` is the word at W(S,k), where W(S,k) keeps the bits of S above the window and sets the low log2(N) bits to (S+k) mod N.
- R7: During beat k, `arr_addr_o` equals W(S,k+1). The address wraps inside its aligned window and never changes the bits above it, whatever `addr_i` does.
- R8: In synchronous mode, an edge with `cs_i` low ends the burst. After it, `rdy_o` and `data_oe_o` are low, and the burst does not resume when `cs_i` returns.
- R9: A new strobe in the middle of a burst drops the current burst at once and starts a new one from the new address, with a fresh latency.
- R10: `data_oe_o` after an edge equals `cs_i AND oe_i` sampled at that edge.
- R11: An edge with `cs_i` and `we_i` high writes `wdata_i` into the array word selected by the low MEM_AW bits of `addr_i`. Later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| avalid_i | input | 1 | Address-valid strobe; starts a burst in synchronous mode |
| oe_i | input | 1 | Output enable request |
| we_i | input | 1 | Array write strobe |
| addr_i | input | ADDR_W | Word address from the host |
| wdata_i | input | DATA_W | Word to write into the array |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_i | input | LAT_W+3 | Configuration word: mode, length code, latency |
| busy_i | input | 1 | Program/erase busy flag, reported in asynchronous mode |
| arr_addr_o | output | ADDR_W | Word address presented to the array |
| rdata_o | output | DATA_W | Word read from the array |
| data_oe_o | output | 1 | Data drive enable; low means the data bus floats |
| rdy_o | output | 1 | Beat valid (synchronous mode) or not busy (asynchronous mode) |

## Verification
The bench uses the defaults: ADDR_W = 23, MEM_AW = 8 and LAT_W = 4. With a 256-word array the bench can keep a full mirror of the array, so every beat is compared against a known word. Start addresses carry set bits well above the array index, so an address that carries out of its window shows up on `arr_addr_o`. A 4-bit latency field gives waits from 0 to 15 clocks. The sweep walks every start offset of all three window sizes with latencies 0 to 2, and table entries go up to 5 and use the reserved length code.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Widest wrap window is 2**LEN_LOG_MAX words.
  localparam int LEN_LOG_MAX = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } seq_state_t;

  // Bits of the address that advance inside the wrap window.
  function automatic logic [LEN_LOG_MAX-1:0] wrap_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 5'b00111;
      2'd1:    return 5'b01111;
      default: return 5'b11111;
    endcase
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LAT_W+2:0] wr_data,
  output logic             sync_mode,
  output logic [1:0]       len_code,
  output logic [LAT_W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_mode <= 1'b0;
      len_code  <= 2'd0;
      lat       <= '0;
    end else if (wr_en) begin
      sync_mode <= wr_data[0];
      len_code  <= wr_data[2:1];
      lat       <= wr_data[LAT_W+2:3];
    end
  end
endmodule

// File: rtl/burst_wrap_next.sv
module burst_wrap_next
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic [ADDR_W-1:0]      cur,
  input  logic [LEN_LOG_MAX-1:0] mask,
  output logic [ADDR_W-1:0]      nxt
);
  logic [LEN_LOG_MAX-1:0] low_inc;
  assign low_inc = cur[LEN_LOG_MAX-1:0] + 1'b1;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < LEN_LOG_MAX) begin : g_win
      assign nxt[i] = mask[i] ? low_inc[i] : cur[i];
    end else begin : g_keep
      assign nxt[i] = cur[i];
    end
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              avalid,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sync_mode,
  input  logic [1:0]        len_code,
  input  logic [LAT_W-1:0]  lat,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rdy
);
  seq_state_t        state;
  logic [LAT_W-1:0]  wait_cnt;
  logic [ADDR_W-1:0] nxt_addr;

  burst_wrap_next #(.ADDR_W(ADDR_W)) u_wrap (
    .cur  (cur_addr),
    .mask (wrap_mask(len_code)),
    .nxt  (nxt_addr)
  );

  // Async: array follows the host; sync: array follows the sequencer.
  assign rd_addr = sync_mode ? cur_addr : addr_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
      cur_addr <= '0;
      rdy      <= 1'b0;
    end else if (!sync_mode) begin
      state <= ST_IDLE;
      rdy   <= ~busy;
      if (cs) cur_addr <= addr_in;
    end else if (!cs) begin
      state <= ST_IDLE;
      rdy   <= 1'b0;
    end else if (avalid) begin
      state    <= ST_WAIT;
      wait_cnt <= lat;
      cur_addr <= addr_in;
      rdy      <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (wait_cnt == '0) begin
            state    <= ST_BURST;
            cur_addr <= nxt_addr;
            rdy      <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_BURST: begin
          cur_addr <= nxt_addr;
          rdy      <= 1'b1;
        end
        default: rdy <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/burst_word_ram.sv
module burst_word_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cs_i,
  input  logic              avalid_i,
  input  logic              oe_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cfg_we_i,
  input  logic [LAT_W+2:0]  cfg_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              data_oe_o,
  output logic              rdy_o
);
  logic              sync_mode;
  logic [1:0]        len_code;
  logic [LAT_W-1:0]  lat;
  logic [ADDR_W-1:0] rd_addr;

  burst_cfg_reg #(.LAT_W(LAT_W)) u_cfg (
    .clk       (clk_i),
    .rst       (rst_i),
    .wr_en     (cs_i & cfg_we_i),
    .wr_data   (cfg_i),
    .sync_mode (sync_mode),
    .len_code  (len_code),
    .lat       (lat)
  );

  burst_seq_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_ctrl (
    .clk       (clk_i),
    .rst       (rst_i),
    .cs        (cs_i),
    .avalid    (avalid_i),
    .busy      (busy_i),
    .addr_in   (addr_i),
    .sync_mode (sync_mode),
    .len_code  (len_code),
    .lat       (lat),
    .rd_addr   (rd_addr),
    .cur_addr  (arr_addr_o),
    .rdy       (rdy_o)
  );

  burst_word_ram #(.AW(MEM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk_i),
    .we    (cs_i & we_i),
    .waddr (addr_i[MEM_AW-1:0]),
    .wdata (wdata_i),
    .raddr (rd_addr[MEM_AW-1:0]),
    .rdata (rdata_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) data_oe_o <= 1'b0;
    else       data_oe_o <= cs_i & oe_i;
  end
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              avalid,
  input logic              oe,
  input logic              busy,
  input logic              sync,
  input logic              rdy,
  input logic              data_oe,
  input logic [ADDR_W-1:0] arr_addr
);
  AST_START_RDY_LOW: assert property (@(posedge clk) disable iff (rst)
    (sync && cs && avalid) |=> !rdy); // R5

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sync && !cs) |=> (!rdy && !data_oe)); // R8

  AST_ASYNC_BUSY_RDY: assert property (@(posedge clk) disable iff (rst)
    (!sync) |=> (rdy == !$past(busy))); // R3

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cs && oe) |=> data_oe); // R10

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !(cs && oe) |=> !data_oe); // R10

  AST_WRAP_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (sync && cs && !avalid) |=>
      (arr_addr[ADDR_W-1:LEN_LOG_MAX] == $past(arr_addr[ADDR_W-1:LEN_LOG_MAX]))); // R7
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk_i),
  .rst      (rst_i),
  .cs       (cs_i),
  .avalid   (avalid_i),
  .oe       (oe_i),
  .busy     (busy_i),
  .sync     (sync_mode),
  .rdy      (rdy_o),
  .data_oe  (data_oe_o),
  .arr_addr (arr_addr_o)
);

// File: tb/burst_seq_top_bench.sv
`timescale 1ns/1ps
module burst_seq_top_bench;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int MW = 8;
  localparam int LW = 4;
  localparam int NVEC = 6;
  // {len_code[28:27], latency[26:23], start address[22:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {2'd0, 4'd0, 23'h00_0005},
    {2'd1, 4'd3, 23'h7F_FF1E},
    {2'd2, 4'd1, 23'h12_3457},
    {2'd3, 4'd2, 23'h40_00BF},
    {2'd0, 4'd5, 23'h55_5567},
    {2'd1, 4'd0, 23'h00_00F0}
  };

  logic clk = 1'b0;
  logic rst, cs, avalid, oe, we, cfg_we, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [LW+2:0] cfg;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] rdata;
  logic data_oe, rdy;

  logic [DW-1:0] exp_mem [1 << MW];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_seq_top #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MW), .LAT_W(LW)) u_burst_seq_top (
    .clk_i(clk), .rst_i(rst), .cs_i(cs), .avalid_i(avalid), .oe_i(oe), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .cfg_we_i(cfg_we), .cfg_i(cfg), .busy_i(busy),
    .arr_addr_o(arr_addr), .rdata_o(rdata), .data_oe_o(data_oe), .rdy_o(rdy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] wrapk(input logic [AW-1:0] s, input logic [1:0] code, input int k);
    int n;
    logic [AW-1:0] m;
    n = (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
    m = AW'(n - 1);
    return (s & ~m) | ((s + AW'(k)) & m);
  endfunction

  function automatic int len_of(input logic [1:0] code);
    return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
  endfunction

  task automatic set_cfg(input logic sm, input logic [1:0] len, input logic [LW-1:0] lat);
    cfg = {lat, len, sm};
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  // R5: strobe edge, then L more edges with rdy low
  task automatic start_burst(input logic [AW-1:0] s, input logic [LW-1:0] lat);
    addr = s;
    avalid = 1'b1;
    tick();
    avalid = 1'b0;
    addr = ~s;
    check(rdy == 1'b0, "R5 rdy after strobe", 32'(rdy), 0);
    for (int i = 0; i < int'(lat); i++) begin
      tick();
      check(rdy == 1'b0, "R5 rdy during latency", 32'(rdy), 0);
    end
  endtask

  task automatic check_beats(input logic [AW-1:0] s, input logic [1:0] len, input int n);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a;
      tick();
      a = wrapk(s, len, k);
      check(rdy == 1'b1, "R6 rdy on beat", 32'(rdy), 1);
      check(rdata == exp_mem[a[MW-1:0]], "R6 beat data", 32'(rdata), 32'(exp_mem[a[MW-1:0]]));
      check(arr_addr == wrapk(s, len, k + 1), "R7 array address", 32'(arr_addr), 32'(wrapk(s, len, k + 1)));
      check(data_oe == 1'b1, "R10 drive on beat", 32'(data_oe), 1);
    end
  endtask

  initial begin
    rst = 1'b1; cs = 1'b0; avalid = 1'b0; oe = 1'b0; we = 1'b0;
    cfg_we = 1'b0; busy = 1'b0; addr = '0; wdata = '0; cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdy == 1'b0, "R1 rdy in reset", 32'(rdy), 0);
    check(data_oe == 1'b0, "R1 oe in reset", 32'(data_oe), 0);
    check(arr_addr == '0, "R1 address in reset", 32'(arr_addr), 0);
    rst = 1'b0;
    busy = 1'b1;
    tick();
    check(rdy == 1'b0, "R1 rdy after reset", 32'(rdy), 0);
    check(data_oe == 1'b0, "R1 oe after reset", 32'(data_oe), 0);

    // R11: load the array in the default mode
    cs = 1'b1; oe = 1'b1; busy = 1'b0; we = 1'b1;
    for (int i = 0; i < (1 << MW); i++) begin
      addr = AW'(i) | 23'h30_0000;
      wdata = DW'(i * 16'h9E37) ^ 16'h5A5A;
      exp_mem[i] = wdata;
      tick();
    end
    we = 1'b0;

    // R2/R11: random single reads (mode still asynchronous after reset, R1)
    begin
      logic [AW-1:0] ra [4] = '{23'h00_0000, 23'h7F_FFFF, 23'h2B_CD3A, 23'h11_1181};
      foreach (ra[j]) begin
        addr = ra[j];
        tick();
        check(arr_addr == ra[j], "R2 async address", 32'(arr_addr), 32'(ra[j]));
        check(rdata == exp_mem[ra[j][MW-1:0]], "R11 R2 async data", 32'(rdata), 32'(exp_mem[ra[j][MW-1:0]]));
      end
    end
    we = 1'b1; addr = 23'h00_00FF; wdata = 16'hBEEF; exp_mem[8'hFF] = 16'hBEEF;
    tick();
    we = 1'b0;
    tick();
    check(rdata == 16'hBEEF, "R11 rewrite readback", 32'(rdata), 32'hBEEF);

    // R3: busy report in asynchronous mode
    busy = 1'b1;
    tick();
    check(rdy == 1'b0, "R3 busy shown", 32'(rdy), 0);
    busy = 1'b0;
    tick();
    check(rdy == 1'b1, "R3 idle shown", 32'(rdy), 1);

    // R4 R6 R7: table of bursts, including reserved length code 3
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] lc;
      logic [LW-1:0] lt;
      logic [AW-1:0] sa;
      lc = VEC[v][28:27];
      lt = VEC[v][26:23];
      sa = VEC[v][22:0];
      set_cfg(1'b1, lc, lt);
      start_burst(sa, lt);
      check_beats(sa, lc, 2 * len_of(lc) + 3);
    end

    // R7: every start offset of every window size
    for (int lc = 0; lc < 3; lc++) begin
      for (int off = 0; off < len_of(2'(lc)); off++) begin
        logic [AW-1:0] sa;
        sa = 23'h2A_0040 | AW'(off);
        set_cfg(1'b1, 2'(lc), LW'(off % 3));
        start_burst(sa, LW'(off % 3));
        check_beats(sa, 2'(lc), len_of(2'(lc)) + 1);
      end
    end

    // R9: restart in mid burst
    set_cfg(1'b1, 2'd1, 4'd2);
    start_burst(23'h12_345A, 4'd2);
    check_beats(23'h12_345A, 2'd1, 3);
    start_burst(23'h00_0077, 4'd2);
    check_beats(23'h00_0077, 2'd1, 20);

    // R8: deselect ends the burst for good
    cs = 1'b0;
    tick();
    check(rdy == 1'b0, "R8 rdy after deselect", 32'(rdy), 0);
    check(data_oe == 1'b0, "R8 oe after deselect", 32'(data_oe), 0);
    cs = 1'b1;
    tick();
    check(rdy == 1'b0, "R8 no resume", 32'(rdy), 0);

    // R10: output enable alone
    oe = 1'b0;
    tick();
    check(data_oe == 1'b0, "R10 oe low", 32'(data_oe), 0);
    oe = 1'b1;
    tick();
    check(data_oe == 1'b1, "R10 oe high", 32'(data_oe), 1);

    // R4: back to asynchronous mode
    set_cfg(1'b0, 2'd0, 4'd0);
    addr = 23'h00_0042;
    tick();
    check(arr_addr == 23'h00_0042, "R4 async again", 32'(arr_addr), 32'h42);
    check(rdy == 1'b1, "R4 R3 rdy not busy", 32'(rdy), 1);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule